// File: doc/BRIEF.md
# MDIO PHY Status Poller

This block is a management-bus master that watches a group of Ethernet PHYs without software involvement. It produces the management clock from the system clock and reads one status register from each PHY in turn, forever. Each read is a standard clause-22 read frame. The 16-bit word that comes back is reduced to three facts: link state, speed and duplex. Each fact is taken from a bit position set at run time, so PHYs whose status layout is vendor specific can still be handled. The results appear as a 2-bit operating mode and a link flag per port.

Polling can be switched off. While it is off, the per-port outputs come straight from force inputs, which set link, speed and duplex by hand. When polling resumes, it picks up with the next port in sequence.

Top module: `mdio_status_poller`

## Requirements
- R1: While reset is asserted and right after it, every port mode is 00, every link flag is 0, `mdio_oe` is 0 and `mdc` is high.
- R2: `mdc` runs continuously. Its high phase and its low phase each last `mdc_half` system clocks, and a setting of 0 counts as 1.
- R3: Each frame drives 32 ones, then start bits 0,1, then read opcode 1,0, then the 5-bit PHY address MSB first, then the 5-bit register address MSB first. The block then releases the line (`mdio_oe` = 0) for 2 turnaround bit times and 16 data bit times. While polling, frames follow each other with no gap.
- R4: `mdio_o` and `mdio_oe` change only on system clock edges where `mdc` falls. `mdio_i` is sampled where `mdc` rises, and the first data bit sampled is status bit 15.
- R5: Ports are read in the order 0,1,...,7 and then start again at 0. The PHY address for port p is (`phy_base` + p) mod 32. The register address is `stat_reg`.
- R6: `port_mode[2p+1:2p]` is {word[`rate_pos`], word[`dplx_pos`]}, coded 00 = 10M half, 01 = 10M full, 10 = 100M half, 11 = 100M full. `port_link[p]` is word[`link_pos`].
- R7: The three bit positions may change at any time. A read is decoded with the positions present when its last data bit is sampled.
- R8: A port's outputs change only on the clock edge where the 16th data bit of that port's own read is sampled. The outputs of the other ports do not change at that edge.
- R9: With `mdio_en` = 0, `port_link[p]` is `force_link[p]` and `port_mode` for port p is {`force_speed[p]`, `force_duplex[p]`}, with no added delay. Any frame already in progress completes, but its result is not kept. No new frame starts, so `mdio_oe` stays 0.
- R10: When `mdio_en` returns to 1, the outputs again show the last polled results, and polling continues with the next port in the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mdio_en | input | 1 | 1 = poll PHYs, 0 = outputs come from force inputs |
| phy_base | input | 5 | PHY address of port 0 |
| stat_reg | input | 5 | PHY register read on every poll |
| rate_pos | input | 4 | Bit position of the speed flag in the status word |
| dplx_pos | input | 4 | Bit position of the duplex flag in the status word |
| link_pos | input | 4 | Bit position of the link flag in the status word |
| mdc_half | input | 8 | System clocks per half period of mdc |
| force_link | input | 8 | Link flags used while polling is off |
| force_speed | input | 8 | Speed flags (1 = 100M) used while polling is off |
| force_duplex | input | 8 | Duplex flags (1 = full) used while polling is off |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data driven by the block |
| mdio_oe | output | 1 | Drive enable for mdio_o |
| mdio_i | input | 1 | Management data returned by the PHY |
| port_mode | output | 16 | 2-bit operating mode per port, port p at bits 2p+1:2p |
| port_link | output | 8 | Link flag per port |

## Verification
If the frame position counter slips, the fault shows within one frame. The header field check fails, or the read data is shifted, which puts the wrong mode on the very next port that updates. A wrong port index shows as a mismatched PHY address in the next header and as results landing on the wrong output slot. A result bank that updates early, or writes several ports at once, shows at the port outputs one MDC period before the last data bit, where the bench compares old and new values. If the force path is gated wrongly, the outputs disagree with the force inputs right after `mdio_en` drops.

// File: rtl/mdio_poll_pkg.sv
package mdio_poll_pkg;

  localparam int          WORD_W     = 16;
  localparam logic [5:0]  PRE_LEN    = 6'd32;
  localparam logic [5:0]  RELEASE_AT = 6'd46;
  localparam logic [5:0]  DATA_AT    = 6'd48;
  localparam logic [5:0]  LAST_POS   = 6'd63;
  localparam logic [3:0]  SOF_OP     = 4'b0110;  // start 01, read 10

  // PHY address for a port: base plus index, wrapping at 32
  function automatic logic [4:0] phy_of_port(input logic [4:0] base,
                                             input logic [4:0] idx);
    return base + idx;
  endfunction

  // Line state for bit position idx of a read frame: {drive_enable, level}
  function automatic logic [1:0] frame_bit(input logic [5:0] idx,
                                           input logic [4:0] phy,
                                           input logic [4:0] regad);
    logic [13:0] hdr;
    logic [3:0]  k;
    hdr = {SOF_OP, phy, regad};
    if (idx < PRE_LEN) begin
      return 2'b11;
    end else if (idx < RELEASE_AT) begin
      k = 4'(6'd45 - idx);
      return {1'b1, hdr[k]};
    end
    return 2'b01;
  endfunction

  // Operating mode: {speed, duplex}
  function automatic logic [1:0] mode_of(input logic [WORD_W-1:0] w,
                                         input logic [3:0] rate_pos,
                                         input logic [3:0] dplx_pos);
    return {w[rate_pos], w[dplx_pos]};
  endfunction

endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] half_div,
  output logic             mdc,
  output logic             rise_stb,
  output logic             fall_stb
);

  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] limit;
  logic             toggle;

  assign limit    = (half_div == '0) ? DIV_W'(1) : half_div;
  assign toggle   = (cnt >= limit - DIV_W'(1));
  // strobes mark the edge at which mdc changes
  assign rise_stb = toggle && !mdc;
  assign fall_stb = toggle &&  mdc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      mdc <= 1'b1;
    end else if (toggle) begin
      cnt <= '0;
      mdc <= !mdc;
    end else begin
      cnt <= cnt + DIV_W'(1);
    end
  end

  // R2: a strobe is never raised on two consecutive edges when the divider is above one
  a_r2_strobe_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_stb || fall_stb) && (limit > DIV_W'(1)) && $stable(half_div)
      |=> !(rise_stb || fall_stb));

endmodule

// File: rtl/mdio_read_engine.sv
module mdio_read_engine
  import mdio_poll_pkg::*;
#(
  parameter int NUM_PORTS = 8,
  parameter int PIDX_W    = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rise_stb,
  input  logic              fall_stb,
  input  logic              poll_en,
  input  logic [4:0]        phy_base,
  input  logic [4:0]        reg_addr,
  input  logic              mdio_i,
  output logic              mdio_o,
  output logic              mdio_oe,
  output logic              done,
  output logic [PIDX_W-1:0] done_port,
  output logic [WORD_W-1:0] done_word
);

  logic [5:0]        pos;
  logic [5:0]        pos_nxt;
  logic [PIDX_W-1:0] port;
  logic [WORD_W-2:0] shreg;
  logic              busy;
  logic              at_end;
  logic              launch;
  logic              advance;
  logic              sample;
  logic [1:0]        line_nxt;

  assign at_end   = (pos == LAST_POS);
  assign pos_nxt  = pos + 6'd1;
  assign launch   = fall_stb && at_end && !busy && poll_en;
  assign advance  = fall_stb && (!at_end || launch);
  assign sample   = rise_stb && busy && (pos >= DATA_AT);
  assign done     = rise_stb && busy && at_end;
  assign line_nxt = frame_bit(pos_nxt, phy_of_port(phy_base, 5'(port)), reg_addr);

  assign done_port = port;
  assign done_word = {shreg, mdio_i};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos     <= LAST_POS;
      busy    <= 1'b0;
      mdio_o  <= 1'b1;
      mdio_oe <= 1'b0;
      shreg   <= '0;
      port    <= '0;
    end else begin
      if (launch)    busy <= 1'b1;
      else if (done) busy <= 1'b0;
      if (advance) begin
        pos     <= pos_nxt;
        mdio_oe <= line_nxt[1];
        mdio_o  <= line_nxt[0];
      end
      if (sample) shreg <= {shreg[WORD_W-3:0], mdio_i};
      if (done) begin
        port <= (port == PIDX_W'(NUM_PORTS - 1)) ? '0 : port + 1'b1;
      end
    end
  end

  // R3: the line is already released when the last data bit is taken
  a_r3_released_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !mdio_oe);

  // R3: every frame opens with a preamble one
  a_r3_frame_opens_with_one: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mdio_oe) |-> mdio_o);

endmodule

// File: rtl/mdio_status_bank.sv
module mdio_status_bank
  import mdio_poll_pkg::*;
#(
  parameter int NUM_PORTS = 8,
  parameter int PIDX_W    = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   poll_en,
  input  logic                   done,
  input  logic [PIDX_W-1:0]      done_port,
  input  logic [WORD_W-1:0]      done_word,
  input  logic [3:0]             rate_pos,
  input  logic [3:0]             dplx_pos,
  input  logic [3:0]             link_pos,
  output logic [2*NUM_PORTS-1:0] mode_q,
  output logic [NUM_PORTS-1:0]   link_q
);

  logic [NUM_PORTS-1:0] wen;
  logic [1:0]           dec_mode;
  logic                 dec_link;

  assign dec_mode = mode_of(done_word, rate_pos, dplx_pos);
  assign dec_link = done_word[link_pos];

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_wen
    assign wen[p] = done && poll_en && (done_port == PIDX_W'(p));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= '0;
      link_q <= '0;
    end else begin
      for (int p = 0; p < NUM_PORTS; p++) begin
        if (wen[p]) begin
          mode_q[2*p +: 2] <= dec_mode;
          link_q[p]        <= dec_link;
        end
      end
    end
  end

  // R8: a completed read writes at most one port slot
  a_r8_single_port_write: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wen));

  // R9: results are frozen while polling is off
  a_r9_frozen_when_forced: assert property (@(posedge clk) disable iff (!rst_n)
    !poll_en |=> ($stable(mode_q) && $stable(link_q)));

endmodule

// File: rtl/mdio_status_poller.sv
module mdio_status_poller
  import mdio_poll_pkg::*;
#(
  parameter int NUM_PORTS = 8,
  parameter int DIV_W     = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   mdio_en,
  input  logic [4:0]             phy_base,
  input  logic [4:0]             stat_reg,
  input  logic [3:0]             rate_pos,
  input  logic [3:0]             dplx_pos,
  input  logic [3:0]             link_pos,
  input  logic [DIV_W-1:0]       mdc_half,
  input  logic [NUM_PORTS-1:0]   force_link,
  input  logic [NUM_PORTS-1:0]   force_speed,
  input  logic [NUM_PORTS-1:0]   force_duplex,
  output logic                   mdc,
  output logic                   mdio_o,
  output logic                   mdio_oe,
  input  logic                   mdio_i,
  output logic [2*NUM_PORTS-1:0] port_mode,
  output logic [NUM_PORTS-1:0]   port_link
);

  localparam int PIDX_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1;

  logic                   rise_stb;
  logic                   fall_stb;
  logic                   rd_done;
  logic [PIDX_W-1:0]      rd_port;
  logic [WORD_W-1:0]      rd_word;
  logic [2*NUM_PORTS-1:0] mode_q;
  logic [NUM_PORTS-1:0]   link_q;

  mdio_mdc_gen #(.DIV_W(DIV_W)) u_clkgen (
    .clk      (clk),
    .rst_n    (rst_n),
    .half_div (mdc_half),
    .mdc      (mdc),
    .rise_stb (rise_stb),
    .fall_stb (fall_stb)
  );

  mdio_read_engine #(.NUM_PORTS(NUM_PORTS), .PIDX_W(PIDX_W)) u_engine (
    .clk       (clk),
    .rst_n     (rst_n),
    .rise_stb  (rise_stb),
    .fall_stb  (fall_stb),
    .poll_en   (mdio_en),
    .phy_base  (phy_base),
    .reg_addr  (stat_reg),
    .mdio_i    (mdio_i),
    .mdio_o    (mdio_o),
    .mdio_oe   (mdio_oe),
    .done      (rd_done),
    .done_port (rd_port),
    .done_word (rd_word)
  );

  mdio_status_bank #(.NUM_PORTS(NUM_PORTS), .PIDX_W(PIDX_W)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .poll_en   (mdio_en),
    .done      (rd_done),
    .done_port (rd_port),
    .done_word (rd_word),
    .rate_pos  (rate_pos),
    .dplx_pos  (dplx_pos),
    .link_pos  (link_pos),
    .mode_q    (mode_q),
    .link_q    (link_q)
  );

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_out
    assign port_mode[2*p +: 2] = mdio_en ? mode_q[2*p +: 2]
                                         : {force_speed[p], force_duplex[p]};
    assign port_link[p]        = mdio_en ? link_q[p] : force_link[p];
  end

  // R4: driven level moves only with a falling mdc
  a_r4_mdio_moves_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mdio_o) |-> $fell(mdc));

  // R4: drive enable moves only with a falling mdc
  a_r4_oe_moves_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mdio_oe) |-> $fell(mdc));

endmodule

// File: tb/sim_mdio_status_poller.sv
module sim_mdio_status_poller;

  localparam int NP = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         mdio_en = 1'b1;
  logic [4:0]   phy_base = 5'd4;
  logic [4:0]   stat_reg = 5'd17;
  logic [3:0]   rate_pos = 4'd13;
  logic [3:0]   dplx_pos = 4'd8;
  logic [3:0]   link_pos = 4'd2;
  logic [7:0]   mdc_half = 8'd2;
  logic [NP-1:0] force_link = '0;
  logic [NP-1:0] force_speed = '0;
  logic [NP-1:0] force_duplex = '0;
  logic         mdc;
  logic         mdio_o;
  logic         mdio_oe;
  logic         mdio_i = 1'b1;
  logic [2*NP-1:0] port_mode;
  logic [NP-1:0]   port_link;

  always #5 clk = ~clk;

  mdio_status_poller u0 (
    .clk(clk), .rst_n(rst_n), .mdio_en(mdio_en), .phy_base(phy_base),
    .stat_reg(stat_reg), .rate_pos(rate_pos), .dplx_pos(dplx_pos),
    .link_pos(link_pos), .mdc_half(mdc_half), .force_link(force_link),
    .force_speed(force_speed), .force_duplex(force_duplex), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i),
    .port_mode(port_mode), .port_link(port_link)
  );

  // {status word, expected mode, expected link} with speed@13, duplex@8, link@2
  localparam logic [18:0] VECS [NP] = '{
    {16'h0000, 2'b00, 1'b0},
    {16'h0004, 2'b00, 1'b1},
    {16'h0104, 2'b01, 1'b1},
    {16'h2004, 2'b10, 1'b1},
    {16'h2104, 2'b11, 1'b1},
    {16'hDEFB, 2'b00, 1'b0},
    {16'hFFFF, 2'b11, 1'b1},
    {16'h2100, 2'b11, 1'b0}
  };

  int checks = 0;
  int errors = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // bench view of decoding: {speed, duplex, link}
  function automatic logic [2:0] decode(input logic [15:0] w, input int r,
                                        input int d, input int l);
    return {w[r], w[d], w[l]};
  endfunction

  // ---------------- PHY model ----------------
  logic [15:0] reply [NP];
  int   ones = 0;
  int   hcnt = 0;
  logic [13:0] hdr = '0;
  bit   in_data = 0;
  bit   oe_bad = 0;
  int   dfall = 0;
  int   frames = 0;
  int   exp_port = 0;
  int   cur_port = 0;
  logic [15:0] cur_word = '0;

  initial begin
    forever begin
      @(mdc);
      if (!rst_n) begin
        ones = 0; hcnt = 0; in_data = 0; dfall = 0;
      end else if (mdc === 1'b1) begin
        if (in_data) begin
          if (mdio_oe) oe_bad = 1;
        end else if (!mdio_oe) begin
          ones = 0; hcnt = 0;
        end else if (hcnt == 0) begin
          if (mdio_o) ones++;
          else begin
            check(ones >= 32, "R3", "preamble ones", ones, 32);
            hdr = 14'd0; hcnt = 1;
          end
        end else begin
          hdr = {hdr[12:0], mdio_o};
          hcnt++;
          if (hcnt == 14) begin
            check(hdr[13:10] == 4'b0110, "R3", "start+opcode", hdr[13:10], 4'b0110);
            check(hdr[9:5] == 5'(phy_base + 5'(exp_port)), "R5", "phy address",
                  hdr[9:5], 5'(phy_base + 5'(exp_port)));
            check(hdr[4:0] == stat_reg, "R5", "register address", hdr[4:0], stat_reg);
            cur_port = exp_port;
            cur_word = reply[exp_port];
            exp_port = (exp_port + 1) % NP;
            in_data = 1; oe_bad = 0; dfall = 0; ones = 0; hcnt = 0;
          end
        end
      end else if (mdc === 1'b0) begin
        if (in_data) begin
          dfall++;
          if (dfall >= 3) mdio_i = cur_word[18 - dfall];
          else mdio_i = 1'b0;
          if (dfall == 18) begin
            check(!oe_bad, "R3", "line released for turnaround and data", oe_bad, 0);
            in_data = 0;
            frames++;
          end
        end
      end
    end
  end

  task automatic wait_frames(input int n);
    int target;
    target = frames + n;
    wait (frames >= target);
  endtask

  // the result lands at the mdc rise that follows the last data fall
  task automatic settle();
    @(posedge mdc);
    @(posedge clk); #1;
  endtask

  task automatic measure_half(input bit level, output int n);
    if (level) @(posedge mdc); else @(negedge mdc);
    n = 0;
    do begin
      @(posedge clk); #1;
      n++;
    end while (mdc == level && n < 1000);
  endtask

  task automatic check_ports(input string req, input int r, input int d, input int l);
    for (int p = 0; p < NP; p++) begin
      logic [2:0] e;
      e = decode(reply[p], r, d, l);
      check(port_mode[2*p +: 2] == e[2:1], req, $sformatf("port %0d mode", p),
            port_mode[2*p +: 2], e[2:1]);
      check(port_link[p] == e[0], req, $sformatf("port %0d link", p), port_link[p], e[0]);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    int n;
    logic [2:0] e_old;
    logic [2:0] e_new;
    logic [2:0] e4;
    for (int p = 0; p < NP; p++) reply[p] = VECS[p][18:3];

    // R1: reset state
    repeat (3) @(posedge clk); #1;
    check(port_mode == '0, "R1", "mode in reset", port_mode, 0);
    check(port_link == '0, "R1", "link in reset", port_link, 0);
    check(mdio_oe == 1'b0, "R1", "oe in reset", mdio_oe, 0);
    check(mdc == 1'b1, "R1", "mdc in reset", mdc, 1);
    rst_n = 1'b1;
    @(posedge clk); #1;
    check(port_mode == '0 && port_link == '0, "R1", "outputs after reset",
          {port_mode, port_link}, 0);

    // R2: half periods at divider 2
    measure_half(1'b1, n);
    check(n == 2, "R2", "mdc high clocks", n, 2);
    measure_half(1'b0, n);
    check(n == 2, "R2", "mdc low clocks", n, 2);

    // R6 / R4: one full round, walk the vector table
    wait_frames(8 - frames);
    settle();
    for (int p = 0; p < NP; p++) begin
      check(port_mode[2*p +: 2] == VECS[p][2:1], "R6", $sformatf("table port %0d mode", p),
            port_mode[2*p +: 2], VECS[p][2:1]);
      check(port_link[p] == VECS[p][0], "R6", $sformatf("table port %0d link", p),
            port_link[p], VECS[p][0]);
    end

    // R7 / R5: new bit positions, wrapping base, new register, slower mdc
    wait_frames(1);
    phy_base = 5'd30; stat_reg = 5'd31;
    rate_pos = 4'd0; dplx_pos = 4'd15; link_pos = 4'd5;
    mdc_half = 8'd5;
    wait_frames(9);
    settle();
    check_ports("R7", 0, 15, 5);
    measure_half(1'b1, n);
    check(n == 5, "R2", "mdc high clocks at 5", n, 5);
    measure_half(1'b0, n);
    check(n == 5, "R2", "mdc low clocks at 5", n, 5);

    // R8: port 3 changes only at its own last data bit
    e_old = decode(reply[3], 0, 15, 5);
    e4    = decode(reply[4], 0, 15, 5);
    for (int p = 0; p < NP; p++) reply[p] = ~reply[p];
    e_new = decode(reply[3], 0, 15, 5);
    wait_frames(1);
    wait (in_data && cur_port == 3 && dfall == 17);
    #1;
    check({port_mode[7:6], port_link[3]} == e_old, "R8", "port 3 before last bit",
          {port_mode[7:6], port_link[3]}, e_old);
    wait (dfall == 18 || !in_data);
    settle();
    check({port_mode[7:6], port_link[3]} == e_new, "R8", "port 3 after last bit",
          {port_mode[7:6], port_link[3]}, e_new);
    check({port_mode[9:8], port_link[4]} == e4, "R8", "port 4 untouched",
          {port_mode[9:8], port_link[4]}, e4);

    // full round so every port holds the inverted words
    wait_frames(9);
    settle();
    check_ports("R8", 0, 15, 5);

    // R9: forced outputs and a quiet bus
    force_link = 8'hA5; force_speed = 8'h3C; force_duplex = 8'h0F;
    mdio_en = 1'b0;
    #1;
    for (int p = 0; p < NP; p++) begin
      check(port_mode[2*p +: 2] == {force_speed[p], force_duplex[p]}, "R9",
            $sformatf("forced port %0d mode", p), port_mode[2*p +: 2],
            {force_speed[p], force_duplex[p]});
      check(port_link[p] == force_link[p], "R9", $sformatf("forced port %0d link", p),
            port_link[p], force_link[p]);
    end
    for (int p = 0; p < NP; p++) e_old = e_old; // keep stored expectation in reply[]
    repeat (700) @(posedge clk);
    n = 0;
    for (int c = 0; c < 2000; c++) begin
      @(posedge clk); #1;
      if (mdio_oe) n++;
    end
    check(n == 0, "R9", "oe cycles while disabled", n, 0);

    // R10: stored results return, then polling resumes
    begin
      logic [15:0] held [NP];
      for (int p = 0; p < NP; p++) begin
        held[p] = reply[p];
        reply[p] = 16'hFFFF;
      end
      mdio_en = 1'b1;
      #1;
      for (int p = 0; p < NP; p++) begin
        logic [2:0] e;
        e = decode(held[p], 0, 15, 5);
        check({port_mode[2*p +: 2], port_link[p]} == e, "R10",
              $sformatf("port %0d restored", p), {port_mode[2*p +: 2], port_link[p]}, e);
      end
    end
    wait_frames(9);
    settle();
    check_ports("R10", 0, 15, 5);

    finish_run();
  end

endmodule